// File: doc/BRIEF.md
# TPM-Cycle Target for the Low Pin Count Bus

This block is the peripheral end of a Low Pin Count (LPC) bus. It claims only TPM-type read and write cycles. Every other cycle type passes by without the block ever driving the shared nibble bus. For each claimed cycle it captures a 16-bit register address and, for writes, one data byte. It hands both to a back-end data provider and inserts long-wait sync nibbles on the bus until the provider answers.

The provider interface uses two handshakes, one for each direction, and both are timed on the falling clock edge. For a write, a valid flag is raised and held until the provider reports that it has taken the byte. For a read, a request flag is raised and held until the provider reports that the byte is ready; the byte is captured at that falling edge. The nibble bus appears as separate input, output and output-enable signals.

A host abort, signalled by the frame line going low at any point, abandons the cycle at once, and the block then decodes the next START. An asynchronous active-low reset, released through a two-stage synchronizer, returns the block to idle.

Top module: `lpc_tpm_target`

## Requirements
- R1: A cycle is claimed only when the START nibble is 0101 and the cycle-type nibble has bits [3:2] = 00. For any other START or type the block never sets `lad_oe_o` and never raises `wr_valid_o` or `rd_req_o`.
- R2: The four address nibbles after the type nibble are taken most significant first, and `addr_o` shows the full 16-bit address whenever either handshake flag is high.
- R3: Bit 1 of the type nibble selects the direction (1 = write, 0 = read; bit 0 is ignored). On a write, the two data nibbles that follow the address are taken low nibble first and presented on `wdata_o`.
- R4: When `lframe_ni` is sampled low, `lad_oe_o` is low from the next clock on and the active handshake is dropped. A START nibble 0101 seen in that same clock begins a new cycle.
- R5: `wr_valid_o` changes only on a falling clock edge. Once set, it stays high until `wr_done_i` is sampled high on a falling edge, or until the cycle is aborted.
- R6: `wr_valid_o` and `rd_req_o` are never high together.
- R7: `rd_req_o` changes only on a falling clock edge. It falls at the falling edge where `rd_ready_i` is sampled high, and `rd_data_i` is captured at that edge.
- R8: The block leaves the bus undriven during the two host turnaround clocks after the address (reads) or after the data (writes). It then drives 0110 in each clock until the provider has answered, and 0000 in the clock in which the answer is seen.
- R9: On a read, the two clocks after the 0000 sync carry the captured byte, low nibble first.
- R10: A claimed cycle ends with one clock of 1111 driven, followed by release of the bus, after which the block is idle.
- R11: While `rst_ni` is low, `lad_oe_o`, `wr_valid_o`, `rd_req_o` and `addr_o` are zero, and this takes effect even in the middle of a cycle. The block works normally again from the second rising edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lframe_ni | input | 1 | Frame strobe from host, active low |
| lad_i | input | 4 | Nibble bus as seen by the target |
| lad_o | output | 4 | Nibble the target drives |
| lad_oe_o | output | 1 | Output enable for `lad_o` |
| addr_o | output | 16 | Register address for the provider |
| wdata_o | output | 8 | Write byte for the provider |
| wr_valid_o | output | 1 | Write byte valid, held until done |
| wr_done_i | input | 1 | Provider has taken the write byte |
| rd_req_o | output | 1 | Read byte requested |
| rd_data_i | input | 8 | Read byte from the provider |
| rd_ready_i | input | 1 | `rd_data_i` is valid |

## Verification
A state machine that loses its place shows up on the bus within one clock. Symptoms include a 0110 or 0000 nibble appearing during the host turnaround, sync never ending, read nibbles arriving swapped, or the closing 1111 missing before release. A handshake stage that falls out of step with the main state shows as a flag that moves on a rising edge, a flag that drops before the provider answers, or both flags high at once. Each of these is visible at the provider ports within half a clock. Abort and reset faults show as a bus still driven one clock after the frame line falls.

// File: rtl/lpc_tpm_pkg.sv
package lpc_tpm_pkg;
  localparam logic [3:0] NIB_START = 4'b0101;
  localparam logic [3:0] NIB_WAIT  = 4'b0110;
  localparam logic [3:0] NIB_READY = 4'b0000;
  localparam logic [3:0] NIB_IDLE  = 4'b1111;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TYPE, ST_ADDR, ST_WDAT, ST_HTAR, ST_SYNC, ST_RDAT, ST_PTAR
  } lpc_state_e;
endpackage

// File: rtl/lpc_tpm_fsm.sv
module lpc_tpm_fsm
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_NIBS = ADDR_W / 4,
  localparam int DATA_NIBS = DATA_W / 4,
  localparam int CNT_W = $clog2(ADDR_NIBS + DATA_NIBS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  input  logic              ack_i,
  output lpc_state_e        state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              is_wr_o,
  output logic              go_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  lpc_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              is_wr_q, is_wr_d, go_q, go_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    is_wr_d = is_wr_q;
    go_d    = go_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (!lframe_ni) begin
      go_d    = 1'b0;
      cnt_d   = '0;
      state_d = (lad_i == NIB_START) ? ST_TYPE : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_TYPE: begin
          if (lad_i[3:2] == 2'b00) begin
            state_d = ST_ADDR;
            is_wr_d = lad_i[1];
          end else begin
            state_d = ST_IDLE;
          end
        end
        ST_ADDR: begin
          addr_d = {addr_q[ADDR_W-5:0], lad_i};
          if (cnt_q == CNT_W'(ADDR_NIBS - 1)) begin
            cnt_d = '0;
            if (is_wr_q) begin
              state_d = ST_WDAT;
            end else begin
              state_d = ST_HTAR;
              go_d    = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_WDAT: begin
          for (int i = 0; i < DATA_NIBS; i++) begin
            if (cnt_q == CNT_W'(i)) wdata_d[i*4 +: 4] = lad_i;
          end
          if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
            cnt_d   = '0;
            state_d = ST_HTAR;
            go_d    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HTAR: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_d   = '0;
            state_d = ST_SYNC;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SYNC: begin
          if (ack_i) begin
            go_d    = 1'b0;
            cnt_d   = '0;
            state_d = is_wr_q ? ST_PTAR : ST_RDAT;
          end
        end
        ST_RDAT: begin
          if (cnt_q == CNT_W'(DATA_NIBS - 1)) begin
            cnt_d   = '0;
            state_d = ST_PTAR;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_PTAR: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      go_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      is_wr_q <= is_wr_d;
      go_q    <= go_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign is_wr_o = is_wr_q;
  assign go_o    = go_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/lpc_tpm_hshake.sv
module lpc_tpm_hshake #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              is_wr_i,
  input  logic              wr_done_i,
  input  logic              rd_ready_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  output logic              rd_req_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic              valid_q, valid_d, req_q, req_d, ack_q, ack_d, cap_en;
  logic [DATA_W-1:0] rdat_q;

  always_comb begin
    valid_d = 1'b0;
    req_d   = 1'b0;
    ack_d   = ack_q;
    cap_en  = 1'b0;
    if (!go_i) begin
      ack_d = 1'b0;
    end else if (!ack_q) begin
      if (is_wr_i) begin
        if (valid_q && wr_done_i) ack_d = 1'b1;
        else valid_d = 1'b1;
      end else begin
        if (req_q && rd_ready_i) begin
          ack_d  = 1'b1;
          cap_en = 1'b1;
        end else begin
          req_d = 1'b1;
        end
      end
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      req_q   <= 1'b0;
      ack_q   <= 1'b0;
      rdat_q  <= '0;
    end else begin
      valid_q <= valid_d;
      req_q   <= req_d;
      ack_q   <= ack_d;
      if (cap_en) rdat_q <= rd_data_i;
    end
  end

  assign wr_valid_o = valid_q;
  assign rd_req_o   = req_q;
  assign ack_o      = ack_q;
  assign rd_data_o  = rdat_q;
endmodule

// File: rtl/lpc_tpm_lad_drv.sv
module lpc_tpm_lad_drv
  import lpc_tpm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W = 3,
  localparam int DATA_NIBS = DATA_W / 4
) (
  input  lpc_state_e        state_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o
);
  always_comb begin
    lad_o    = NIB_IDLE;
    lad_oe_o = 1'b0;
    unique case (state_i)
      ST_SYNC: begin
        lad_oe_o = 1'b1;
        lad_o    = ack_i ? NIB_READY : NIB_WAIT;
      end
      ST_RDAT: begin
        lad_oe_o = 1'b1;
        for (int i = 0; i < DATA_NIBS; i++) begin
          if (cnt_i == CNT_W'(i)) lad_o = rdata_i[i*4 +: 4];
        end
      end
      ST_PTAR: lad_oe_o = (cnt_i == '0);
      default: ;
    endcase
  end
endmodule

// File: rtl/lpc_tpm_target.sv
module lpc_tpm_target
  import lpc_tpm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(ADDR_W / 4 + DATA_W / 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lframe_ni,
  input  logic [3:0]        lad_i,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wr_valid_o,
  input  logic              wr_done_i,
  output logic              rd_req_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_ready_i
);
  logic [1:0]        rst_q;
  logic              rst_sync_n;
  lpc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr, go, ack;
  logic [DATA_W-1:0] rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  lpc_tpm_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .lframe_ni(lframe_ni), .lad_i(lad_i),
    .ack_i(ack), .state_o(state), .cnt_o(cnt), .is_wr_o(is_wr), .go_o(go),
    .addr_o(addr_o), .wdata_o(wdata_o)
  );

  lpc_tpm_hshake #(.DATA_W(DATA_W)) u_hs (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .go_i(go), .is_wr_i(is_wr),
    .wr_done_i(wr_done_i), .rd_ready_i(rd_ready_i), .rd_data_i(rd_data_i),
    .wr_valid_o(wr_valid_o), .rd_req_o(rd_req_o), .ack_o(ack), .rd_data_o(rdata)
  );

  lpc_tpm_lad_drv #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_drv (
    .state_i(state), .cnt_i(cnt), .ack_i(ack), .rdata_i(rdata),
    .lad_o(lad_o), .lad_oe_o(lad_oe_o)
  );
endmodule

// File: rtl/lpc_tpm_target_chk.sv
module lpc_tpm_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lframe_ni,
  input logic [3:0] lad_o,
  input logic       lad_oe_o,
  input logic       wr_valid_o,
  input logic       wr_done_i,
  input logic       rd_req_o,
  input logic       rd_ready_i,
  input logic       go_i
);
  AST_HS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_o && rd_req_o)); // R6

  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lframe_ni |=> !lad_oe_o); // R4

  AST_WRV_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(wr_valid_o) |-> ($past(wr_done_i) || !$past(go_i))); // R5

  AST_RDREQ_HOLD: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(rd_req_o) |-> ($past(rd_ready_i) || !$past(go_i))); // R7

  AST_END_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lad_oe_o) |-> ($past(lad_o) == 4'hF || !$past(lframe_ni))); // R10
endmodule

bind lpc_tpm_target lpc_tpm_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_sync_n), .lframe_ni(lframe_ni), .lad_o(lad_o),
  .lad_oe_o(lad_oe_o), .wr_valid_o(wr_valid_o), .wr_done_i(wr_done_i),
  .rd_req_o(rd_req_o), .rd_ready_i(rd_ready_i), .go_i(go)
);

// File: tb/lpc_tpm_target_bench.sv
`timescale 1ns/1ps
module lpc_tpm_target_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni, lframe_ni, wr_done_i, rd_ready_i;
  logic [3:0]  lad_i, lad_o;
  logic        lad_oe_o, wr_valid_o, rd_req_o;
  logic [15:0] addr_o;
  logic [7:0]  wdata_o, rd_data_i;

  int n_chk = 0, n_fail = 0;
  int prov_lat = 0;
  logic [7:0] prov_data = '0;
  logic [15:0] got_addr;
  logic [7:0]  got_wdata;
  int hs_cnt = 0, edge_bad = 0, both_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  lpc_tpm_target u_lpc_tpm_target (
    .clk_i(clk_i), .rst_ni(rst_ni), .lframe_ni(lframe_ni), .lad_i(lad_i),
    .lad_o(lad_o), .lad_oe_o(lad_oe_o), .addr_o(addr_o), .wdata_o(wdata_o),
    .wr_valid_o(wr_valid_o), .wr_done_i(wr_done_i), .rd_req_o(rd_req_o),
    .rd_data_i(rd_data_i), .rd_ready_i(rd_ready_i)
  );

  // {type nibble, address, data byte, provider latency}
  localparam logic [31:0] VEC [8] = '{
    32'h20F00A50, 32'h00F183C0, 32'h3FFFF003, 32'h10000FF5,
    32'h40F00110, 32'hA1234220, 32'h01234811, 32'h2ABCD7E2
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fr, input logic [3:0] nib);
    @(negedge clk_i);
    lframe_ni = fr;
    lad_i     = nib;
    #2;
  endtask

  // Provider model: answers after prov_lat rising edges.
  initial begin
    int pcnt = 0;
    wr_done_i = 1'b0; rd_ready_i = 1'b0; rd_data_i = '0;
    forever begin
      @(posedge clk_i);
      if (!rst_ni) begin
        wr_done_i = 1'b0; rd_ready_i = 1'b0; pcnt = 0;
      end else if (wr_valid_o && !wr_done_i) begin
        hs_cnt++;
        if (pcnt >= prov_lat) begin
          wr_done_i = 1'b1; got_wdata = wdata_o; got_addr = addr_o; pcnt = 0;
        end else pcnt++;
      end else if (rd_req_o && !rd_ready_i) begin
        hs_cnt++;
        if (pcnt >= prov_lat) begin
          rd_data_i = prov_data; rd_ready_i = 1'b1; got_addr = addr_o; pcnt = 0;
        end else pcnt++;
      end else begin
        if (!wr_valid_o) wr_done_i = 1'b0;
        if (!rd_req_o) rd_ready_i = 1'b0;
        pcnt = 0;
      end
    end
  end

  // Handshake flags must not move at a rising edge (R5, R7); never both high (R6).
  initial begin
    forever begin
      logic sv, sr, sr_rst;
      @(negedge clk_i); #1;
      sv = wr_valid_o; sr = rd_req_o; sr_rst = rst_ni;
      if (wr_valid_o && rd_req_o) both_cnt++;
      @(posedge clk_i); #1;
      if (sr_rst && rst_ni && (wr_valid_o !== sv || rd_req_o !== sr)) edge_bad++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail + 1);
    $finish;
  end

  task automatic run_cycle(input logic [31:0] v, input string tag);
    logic [3:0] ct = v[31:28];
    logic [15:0] a = v[27:12];
    logic [7:0] d = v[11:4];
    int lat = int'(v[3:0]);
    bit claim = (ct[3:2] == 2'b00);
    bit wr = ct[1];
    bit any_oe = 0;
    int hs0, waits = 0, expw;
    logic [3:0] n0, n1;
    prov_lat = lat; prov_data = d; hs0 = hs_cnt;
    drive(1'b0, 4'b0101); any_oe |= lad_oe_o;
    drive(1'b1, ct);      any_oe |= lad_oe_o;
    for (int i = 0; i < 4; i++) begin drive(1'b1, a[(3-i)*4 +: 4]); any_oe |= lad_oe_o; end
    if (wr) for (int i = 0; i < 2; i++) begin drive(1'b1, d[i*4 +: 4]); any_oe |= lad_oe_o; end
    for (int i = 0; i < 2; i++) begin drive(1'b1, 4'hF); any_oe |= lad_oe_o; end
    if (!claim) begin
      for (int i = 0; i < 8; i++) begin drive(1'b1, 4'hF); any_oe |= lad_oe_o; end
      chk(!any_oe && hs_cnt == hs0, {tag, " R1 ignored type"}, {any_oe, hs_cnt - hs0}, 0);
      return;
    end
    chk(!any_oe, {tag, " R8 quiet through turnaround"}, any_oe, 0);
    for (int i = 0; i < 40; i++) begin
      drive(1'b1, 4'hF);
      if (lad_oe_o && lad_o == 4'b0110) waits++;
      else break;
    end
    expw = (lat > 0) ? lat - 1 : 0;
    chk(lad_oe_o && lad_o == 4'b0000, {tag, " R8 ready sync"}, {lad_oe_o, lad_o}, 5'h10);
    chk(waits == expw, {tag, " R8 wait count"}, waits, expw);
    if (!wr) begin
      drive(1'b1, 4'hF); n0 = lad_o; any_oe = lad_oe_o;
      drive(1'b1, 4'hF); n1 = lad_o; any_oe &= lad_oe_o;
      chk(any_oe && {n1, n0} == d, {tag, " R9 read byte"}, {n1, n0}, d);
    end
    drive(1'b1, 4'hF);
    chk(lad_oe_o && lad_o == 4'hF, {tag, " R10 closing 1111"}, {lad_oe_o, lad_o}, 5'h1F);
    drive(1'b1, 4'hF);
    chk(!lad_oe_o, {tag, " R10 release"}, lad_oe_o, 0);
    chk(got_addr == a, {tag, " R2 address"}, got_addr, a);
    if (wr) chk(got_wdata == d, {tag, " R3 write byte"}, got_wdata, d);
    else chk(!rd_req_o, {tag, " R7 request dropped"}, rd_req_o, 0);
  endtask

  initial begin
    rst_ni = 1'b0; lframe_ni = 1'b0; lad_i = 4'b0101;
    repeat (3) @(negedge clk_i);
    #2;
    chk(!lad_oe_o && !wr_valid_o && !rd_req_o && addr_o == 0, "R11 reset state",
        {lad_oe_o, wr_valid_o, rd_req_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1; lframe_ni = 1'b1; lad_i = 4'hF;
    repeat (4) drive(1'b1, 4'hF);

    for (int k = 0; k < 8; k++) run_cycle(VEC[k], $sformatf("vec%0d", k));

    // Abort during sync of a slow read (R4)
    prov_lat = 12;
    drive(1'b0, 4'b0101); drive(1'b1, 4'h0);
    for (int i = 0; i < 4; i++) drive(1'b1, 4'h3);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    drive(1'b1, 4'hF);
    chk(lad_oe_o && lad_o == 4'b0110 && rd_req_o, "R8 waiting before abort",
        {lad_oe_o, lad_o, rd_req_o}, 6'h2D);
    drive(1'b0, 4'hF);
    drive(1'b0, 4'hF);
    chk(!lad_oe_o, "R4 bus released after abort", lad_oe_o, 0);
    chk(!rd_req_o, "R4 request dropped on abort", rd_req_o, 0);
    drive(1'b0, 4'hF); drive(1'b0, 4'hF); drive(1'b1, 4'hF);
    run_cycle(32'h2_0F24_5A_1, "after-abort R4");

    // Abort in address phase, new START with no idle clock (R4)
    drive(1'b0, 4'b0101); drive(1'b1, 4'h2); drive(1'b1, 4'h9); drive(1'b1, 4'h9);
    run_cycle(32'h0_0F30_C3_2, "restart R4");

    // Reset in the middle of a write (R11)
    prov_lat = 15;
    drive(1'b0, 4'b0101); drive(1'b1, 4'h2);
    for (int i = 0; i < 4; i++) drive(1'b1, 4'h1);
    drive(1'b1, 4'h6); drive(1'b1, 4'h6);
    drive(1'b1, 4'hF); drive(1'b1, 4'hF); drive(1'b1, 4'hF);
    chk(wr_valid_o && lad_oe_o, "R5 valid held while provider slow",
        {wr_valid_o, lad_oe_o}, 2'b11);
    rst_ni = 1'b0; #0.5;
    chk(!wr_valid_o && !lad_oe_o && addr_o == 0, "R11 async clear mid-cycle",
        {wr_valid_o, lad_oe_o, addr_o}, 0);
    repeat (3) drive(1'b1, 4'hF);
    @(negedge clk_i); rst_ni = 1'b1;
    repeat (3) drive(1'b1, 4'hF);
    run_cycle(32'h0_0F0C_E7_0, "post-reset R11");

    chk(edge_bad == 0, "R5 R7 flags move only on falling edge", edge_bad, 0);
    chk(both_cnt == 0, "R6 flags exclusive", both_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule